// File: doc/BRIEF.md
# Serial Input Bit Delay Aligner

This block realigns one serial input stream of a time-division-multiplexed backplane. It runs on a clock at four times the bit rate, so every bit cell spans four clock cycles, or quarter-bit ticks. A frame pulse marks the nominal start of bit 0. A programmed offset then says where bit 0 really begins on the wire and which quarter of each bit cell is sampled. The block outputs one realigned bit per bit period with a single-cycle strobe and a bit index counted from the frame start. Several streams are handled by placing one copy of the block on each stream.

A 16-bit configuration register sets the offset. Only its low five bits are stored. A global sample-mode input chooses how those five bits are read. With the mode low, the field is one delay in quarter-bit units, and the sample point is fixed at the three-quarter point of the bit cell. With the mode high, the upper three bits give a whole-bit delay and the lower two bits pick the quarter within the cell. The register value and the mode are both taken into use only at a frame pulse, so a frame in progress is never disturbed.

The output is source-timed. A bit that is presented is never stalled. The strobe marks a new bit, and the data and index hold between strobes, so a consumer can take them at any point in that window. There is no back-pressure path, because the serial input cannot be paused.

Top module: `sbit_aligner`

## Requirements
- R1: While reset is held, and after reset until the first frame pulse, `bit_valid` is 0. During reset, `bit_data`, `bit_idx` and `cfg_rdata` are 0.
- R2: When `cfg_wr` is 1 at a clock edge, the low five bits of `cfg_wdata` are stored. From the next cycle, `cfg_rdata` shows those five bits in positions 4:0 and zeros in positions 15:5, whatever was written to them.
- R3: With the latched mode low and field value F, let `f` be the clock edge that took the frame pulse. The bit with index n equals `ser_in` as sampled at edge f+F+2+4n. This is the three-quarter point of a cell delayed by F quarter bits.
- R4: With the latched mode high, let D be field bits 4:2 and P be field bits 1:0. Bit n equals `ser_in` at edge f+4·D+P+4n. Codes 0, 1, 2 and 3 of P select the ¼, 2/4, ¾ and 4/4 points in that order.
- R5: `bit_valid` is high for exactly one cycle per bit. It becomes high after edge f+34+4n, a fixed latency that does not depend on the configuration.
- R6: Between strobes, `bit_data` and `bit_idx` do not change.
- R7: `bit_idx` is 0 on the first strobe after a frame pulse and rises by one on each later strobe of that frame.
- R8: The field value and the sample mode in force are the ones present at the frame-pulse edge. Writes to the register and changes of the mode input in the middle of a frame have no effect until the next frame pulse.
- R9: A frame pulse restarts the bit sequence. No strobe is produced on the cycle after the pulse edge, and the next strobe follows the R5 latency counted from the new pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at four times the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_in | input | 1 | Serial input stream |
| frame_pulse | input | 1 | One-cycle frame start marker |
| sample_mode | input | 1 | Offset interpretation: 0 = quarter delay at the ¾ point, 1 = whole-bit delay with a sample phase |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read-back |
| bit_valid | output | 1 | One-cycle strobe for each realigned bit |
| bit_data | output | 1 | Realigned bit value |
| bit_idx | output | IDX_W | Bit index within the frame |

## Verification
The hardest case to reach is a configuration change that overlaps a running frame. This includes a write or a mode flip while strobes are still coming out, and a frame pulse that arrives before the fixed latency has run out. The stimulus writes random values, with random reserved bits, and flips the mode in the middle of each frame. It also mixes short random frame lengths with long ones, so that restarts cut off pending bits. A reference model that latches its settings only at frame pulses predicts every strobe, bit and index. Random data on every quarter tick makes each sample-point choice give a different result.

// File: rtl/sbit_aligner_pkg.sv
package sbit_aligner_pkg;
  localparam int REG_W     = 16;
  localparam int FIELD_W   = 5;
  localparam int QTR       = 4;
  localparam int FIX_PHASE = 2;
  localparam int MAX_OFF   = (1 << FIELD_W) - 1 + FIX_PHASE;
  localparam int DEPTH     = MAX_OFF + 1;
  localparam int OFF_W     = $clog2(DEPTH);

  typedef logic [FIELD_W-1:0] field_t;
  typedef logic [OFF_W-1:0]   off_t;

  // Total quarter-tick offset of bit 0's sample point from the frame edge.
  // Mode high: field[4:2] whole bits, field[1:0] quarter phase -> the field itself.
  function automatic off_t total_offset(input logic mode, input field_t f);
    off_t r;
    if (mode) r = off_t'(f);
    else      r = off_t'(f) + off_t'(FIX_PHASE);
    return r;
  endfunction
endpackage

// File: rtl/sbit_aligner_cfg.sv
module sbit_aligner_cfg
  import sbit_aligner_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             frame_pulse,
  input  logic             sample_mode,
  output logic [REG_W-1:0] rdata,
  output off_t             act_off
);
  field_t pend_q;
  off_t   act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      if (frame_pulse) act_q <= total_offset(sample_mode, pend_q);
      if (wr)          pend_q <= wdata[FIELD_W-1:0];
    end
  end

  assign rdata   = {{(REG_W-FIELD_W){1'b0}}, pend_q};
  assign act_off = act_q;
endmodule

// File: rtl/sbit_aligner_tapline.sv
module sbit_aligner_tapline
  import sbit_aligner_pkg::*;
#(
  parameter int N = DEPTH
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 din,
  input  logic [$clog2(N)-1:0] sel,
  output logic                 tap
);
  logic [N-1:0] line_q;

  for (genvar i = 0; i < N; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) line_q[0] <= 1'b0;
        else        line_q[0] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) line_q[i] <= 1'b0;
        else        line_q[i] <= line_q[i-1];
      end
    end
  end

  assign tap = line_q[sel];
endmodule

// File: rtl/sbit_aligner_timer.sv
module sbit_aligner_timer
  import sbit_aligner_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_pulse,
  output logic             take,
  output logic             valid,
  output logic [IDX_W-1:0] idx
);
  localparam off_t LAST = off_t'(MAX_OFF);

  off_t             elap_q;
  logic [1:0]       qtr_q;
  logic             run_q, first_q, valid_q;
  logic [IDX_W-1:0] idx_q;

  assign take = run_q && (elap_q == LAST) && (qtr_q == 2'd0) && !frame_pulse;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      elap_q  <= '0;
      qtr_q   <= '0;
      run_q   <= 1'b0;
      first_q <= 1'b0;
      valid_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      valid_q <= take;
      if (frame_pulse) begin
        elap_q  <= '0;
        qtr_q   <= '0;
        run_q   <= 1'b1;
        first_q <= 1'b1;
      end else if (run_q) begin
        if (elap_q != LAST) elap_q <= elap_q + off_t'(1);
        else                qtr_q  <= qtr_q + 2'd1;
      end
      if (take) begin
        first_q <= 1'b0;
        idx_q   <= first_q ? '0 : idx_q + 1'b1;
      end
    end
  end

  assign valid = valid_q;
  assign idx   = idx_q;
endmodule

// File: rtl/sbit_aligner.sv
module sbit_aligner
  import sbit_aligner_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_in,
  input  logic             frame_pulse,
  input  logic             sample_mode,
  input  logic             cfg_wr,
  input  logic [15:0]      cfg_wdata,
  output logic [15:0]      cfg_rdata,
  output logic             bit_valid,
  output logic             bit_data,
  output logic [IDX_W-1:0] bit_idx
);
  off_t act_off;
  off_t sel;
  logic tap, take, data_q;

  sbit_aligner_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata),
    .frame_pulse(frame_pulse), .sample_mode(sample_mode),
    .rdata(cfg_rdata), .act_off(act_off)
  );

  // The sample is taken at a fixed latency, so the tap depth is the slack.
  assign sel = off_t'(MAX_OFF) - act_off;

  sbit_aligner_tapline #(.N(DEPTH)) u_line (
    .clk(clk), .rst_n(rst_n), .din(ser_in), .sel(sel), .tap(tap)
  );

  sbit_aligner_timer #(.IDX_W(IDX_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse),
    .take(take), .valid(bit_valid), .idx(bit_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    data_q <= 1'b0;
    else if (take) data_q <= tap;
  end

  assign bit_data = data_q;
endmodule

// File: rtl/sbit_aligner_chk.sv
module sbit_aligner_chk #(
  parameter int IDX_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_pulse,
  input logic             cfg_wr,
  input logic [15:0]      cfg_wdata,
  input logic [15:0]      cfg_rdata,
  input logic             bit_valid,
  input logic             bit_data,
  input logic [IDX_W-1:0] bit_idx
);
  logic             seen_fp;
  logic [IDX_W-1:0] last_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_fp  <= 1'b0;
      last_idx <= '0;
    end else begin
      if (frame_pulse) seen_fp <= 1'b1;
      if (bit_valid)   last_idx <= bit_idx;
    end
  end

  // R1
  idle_before_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_fp |-> !bit_valid);
  // R2
  readback_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> cfg_rdata == {11'b0, $past(cfg_wdata[4:0])});
  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> !bit_valid);
  // R6
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |-> $stable(bit_data) && $stable(bit_idx));
  // R7
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && bit_idx != '0) |-> bit_idx == last_idx + 1'b1);
  // R9
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |=> !bit_valid);
endmodule

bind sbit_aligner sbit_aligner_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .cfg_wr(cfg_wr),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bit_valid(bit_valid),
  .bit_data(bit_data), .bit_idx(bit_idx)
);

// File: tb/sbit_aligner_tb.sv
module sbit_aligner_tb;
  localparam int IDX_W = 10;
  localparam int LAT   = 34;
  localparam int HMAX  = 16384;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_in = 1'b0, frame_pulse = 1'b0, sample_mode = 1'b0, cfg_wr = 1'b0;
  logic [15:0] cfg_wdata = '0, cfg_rdata;
  logic bit_valid, bit_data;
  logic [IDX_W-1:0] bit_idx;

  always #4 clk = ~clk;

  sbit_aligner #(.IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .frame_pulse(frame_pulse),
    .sample_mode(sample_mode), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .bit_valid(bit_valid), .bit_data(bit_data),
    .bit_idx(bit_idx)
  );

  int checks = 0, fails = 0;
  bit hist [HMAX];
  int k = 0, lf = -1, act_t = 0;
  bit act_mode = 1'b0;
  logic [4:0] pend = '0, act_field = '0;
  logic exp_data = 1'b0;
  logic [IDX_W-1:0] exp_idx = '0;
  bit done = 1'b0;

  function automatic int offset_of(bit mode, logic [4:0] f);
    return mode ? int'(f) : int'(f) + 2;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d actual %0d expected %0d", req, k, act, exp);
    end
  endtask

  task automatic cycle(bit fp, bit wr, logic [15:0] wd);
    bit ev;
    int n;
    string tag;
    ser_in = 1'($urandom);
    frame_pulse = fp; cfg_wr = wr; cfg_wdata = wd;
    hist[k] = ser_in;
    @(posedge clk);
    if (fp) begin
      lf = k; act_mode = sample_mode; act_field = pend;
      act_t = offset_of(sample_mode, pend);
    end
    if (wr) pend = wd[4:0];
    @(negedge clk);
    ev = (lf >= 0) && (k - lf >= LAT) && (((k - lf - LAT) % 4) == 0);
    check(bit_valid == ev, lf < 0 ? "R1" : "R5 R9", int'(bit_valid), int'(ev));
    if (ev) begin
      n = (k - lf - LAT) / 4;
      exp_data = hist[lf + act_t + 4 * n];
      exp_idx = IDX_W'(n);
      if (act_field != pend || act_mode != sample_mode) tag = "R8";
      else tag = act_mode ? "R4" : "R3";
      check(bit_data == exp_data, tag, int'(bit_data), int'(exp_data));
      check(bit_idx == exp_idx, "R7", int'(bit_idx), int'(exp_idx));
    end else begin
      check(bit_data == exp_data && bit_idx == exp_idx, "R6",
            int'({bit_idx, bit_data}), int'({exp_idx, exp_data}));
    end
    check(cfg_rdata == {11'b0, pend}, "R2", int'(cfg_rdata), int'({11'b0, pend}));
    k++;
  endtask

  task automatic frame(int len, bit mode, logic [4:0] fld);
    sample_mode = mode;
    cycle(1'b0, 1'b1, {11'($urandom), fld});
    cycle(1'b1, 1'b0, '0);
    for (int i = 2; i < len; i++) begin
      if (i == len / 2) begin
        sample_mode = ~sample_mode;
        cycle(1'b0, 1'b1, 16'($urandom));
      end else begin
        cycle(1'b0, 1'b0, '0);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd715));
    repeat (3) begin
      @(negedge clk);
      check(bit_valid == 0 && bit_data == 0 && bit_idx == 0, "R1",
            int'({bit_idx, bit_data, bit_valid}), 0);
      check(cfg_rdata == 0, "R1", int'(cfg_rdata), 0);
    end
    rst_n = 1'b1;
    repeat (40) cycle(1'b0, 1'b0, '0);
    frame(130, 1'b0, 5'd0);
    frame(130, 1'b0, 5'd31);
    frame(130, 1'b1, 5'd0);
    frame(130, 1'b1, 5'd1);
    frame(130, 1'b1, 5'd2);
    frame(130, 1'b1, 5'd3);
    frame(130, 1'b1, 5'd31);
    frame(130, 1'b1, 5'd28);
    frame(20, 1'b0, 5'd9);
    frame(37, 1'b1, 5'd17);
    for (int j = 0; j < 40; j++)
      frame(30 + int'($urandom % 140), 1'($urandom), 5'($urandom));
    repeat (60) cycle(1'b0, 1'b0, '0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog cycle %0d actual 0 expected 1", k);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule